// File: doc/BRIEF.md
# Row-Locality-Aware Cache Insertion Filter

This block sits beside the controller of a slow non-volatile main memory that has a small, fast DRAM cache in front of it. It decides which rows are worth copying into that cache. Every access to the slow memory arrives with its row address and a flag that says whether it hit the open row buffer. The block keeps a small direct-mapped table of recently seen rows. Each entry holds a saturating count of row-buffer misses and a saturating count of reuses.

A row-buffer hit costs about the same in either memory, so hits never raise the miss count. A row that misses often and also comes back often is worth the cost of moving it. When both counts reach their thresholds, the block raises a one-cycle migrate request that carries the row address, and it frees the entry. Accesses that the DRAM cache already serves are ignored. Every EPOCH_LEN slow-memory accesses the whole table is wiped, so that old history ages out.

Top module: `rlf_top`

## Requirements
- R1: After a synchronous reset, `mig_valid` is low and every table entry is empty.
- R2: A slow-memory access that hits the row buffer on a matching entry raises that entry's reuse count only. It never raises the miss count.
- R3: An access with `acc_in_cache` high changes nothing. It does not touch the table, it does not advance the epoch count and it never causes a migrate.
- R4: A slow-memory access can leave its entry with a miss count of at least MISS_THR and a reuse count of at least REUSE_THR. When it does, `mig_valid` is high for exactly the cycle after the access edge, and `mig_row` equals the accessed row.
- R5: A row whose reuse count is high but whose miss count is below MISS_THR is never migrated.
- R6: The migrating access frees its entry. The next access to that row starts a new entry: miss count 1 on a row miss or 0 on a row hit, and reuse count 0.
- R7: The entry index is `acc_row[IDX_W-1:0]` and the tag is the remaining upper bits. The first access to an entry, or an access whose tag differs from the stored tag, replaces the entry. The new entry starts with reuse count 0 and a miss count of 1 on a row miss or 0 on a row hit. A matching access adds 1 to the reuse count.
- R8: Slow-memory accesses are counted from reset. The access that completes each group of EPOCH_LEN empties the whole table. Its own update is dropped and it causes no migrate.
- R9: Both counts saturate at 2^CNT_W-1 and do not wrap.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| acc_valid | input | 1 | An access is presented this cycle |
| acc_row | input | ROW_W | Row address of the access |
| acc_row_hit | input | 1 | The access hit the open row buffer |
| acc_in_cache | input | 1 | The access is served by the DRAM cache |
| mig_valid | output | 1 | One-cycle migrate request |
| mig_row | output | ROW_W | Row to copy into the DRAM cache |

## Verification
The bench builds the block with ROW_W=12, IDX_W=2, CNT_W=3, MISS_THR=3, REUSE_THR=4 and EPOCH_LEN=40. With a 3-bit counter, fourteen row hits are enough to show that the reuse count saturates instead of wrapping. If it wrapped, the later migrate would be lost. With a 40-access epoch, a single scenario can place the table wipe exactly between the third and fourth misses of a row that is about to qualify. The small index width makes tag conflicts at a shared entry easy to provoke.

// File: rtl/rlf_pkg.sv
package rlf_pkg;

    typedef enum logic [1:0] {
        ACC_NONE     = 2'd0,
        ACC_CACHED   = 2'd1,
        ACC_ROW_HIT  = 2'd2,
        ACC_ROW_MISS = 2'd3
    } acc_kind_e;

    function automatic acc_kind_e classify(input logic valid,
                                           input logic in_cache,
                                           input logic row_hit);
        if (!valid)
            return ACC_NONE;
        if (in_cache)
            return ACC_CACHED;
        return row_hit ? ACC_ROW_HIT : ACC_ROW_MISS;
    endfunction

    function automatic logic is_slow(input acc_kind_e k);
        return (k == ACC_ROW_HIT) || (k == ACC_ROW_MISS);
    endfunction

endpackage

// File: rtl/rlf_epoch.sv
module rlf_epoch
    import rlf_pkg::*;
#(
    parameter int EPOCH_LEN = 40
) (
    input  logic      clk,
    input  logic      rst,
    input  acc_kind_e kind,
    output logic      clear
);
    localparam int CW = (EPOCH_LEN > 1) ? $clog2(EPOCH_LEN) : 1;
    localparam logic [CW-1:0] LAST = CW'(EPOCH_LEN - 1);

    logic [CW-1:0] cnt;

    assign clear = is_slow(kind) && (cnt == LAST);

    always_ff @(posedge clk) begin
        if (rst)
            cnt <= '0;
        else if (clear)
            cnt <= '0;
        else if (is_slow(kind))
            cnt <= cnt + 1'b1;
    end

    // R8: the access count never runs past the epoch length
    a_r8_epoch_bound: assert property (@(posedge clk) disable iff (rst)
        32'(cnt) < EPOCH_LEN);

endmodule

// File: rtl/rlf_table.sv
module rlf_table
    import rlf_pkg::*;
#(
    parameter int ROW_W     = 16,
    parameter int IDX_W     = 3,
    parameter int CNT_W     = 3,
    parameter int MISS_THR  = 3,
    parameter int REUSE_THR = 4
) (
    input  logic             clk,
    input  logic             rst,
    input  acc_kind_e        kind,
    input  logic [ROW_W-1:0] row,
    input  logic             clear,
    output logic             mig_valid,
    output logic [ROW_W-1:0] mig_row
);
    localparam int DEPTH = 1 << IDX_W;
    localparam int TAG_W = ROW_W - IDX_W;
    localparam logic [CNT_W-1:0] CMAX  = {CNT_W{1'b1}};
    localparam logic [CNT_W-1:0] M_THR = CNT_W'(MISS_THR);
    localparam logic [CNT_W-1:0] R_THR = CNT_W'(REUSE_THR);

    typedef struct packed {
        logic             vld;
        logic [TAG_W-1:0] tag;
        logic [CNT_W-1:0] miss;
        logic [CNT_W-1:0] reuse;
    } ent_t;

    ent_t tbl [DEPTH];

    logic [IDX_W-1:0] idx;
    logic [TAG_W-1:0] tg;
    ent_t             cur, nxt;
    logic             match, is_miss, fire, slow;

    always_comb begin
        idx     = row[IDX_W-1:0];
        tg      = row[ROW_W-1:IDX_W];
        cur     = tbl[idx];
        slow    = is_slow(kind);
        is_miss = (kind == ACC_ROW_MISS);
        match   = cur.vld && (cur.tag == tg);
        nxt.vld = 1'b1;
        nxt.tag = tg;
        if (match) begin
            nxt.reuse = (cur.reuse == CMAX) ? CMAX : cur.reuse + 1'b1;
            nxt.miss  = (is_miss && cur.miss != CMAX) ? cur.miss + 1'b1 : cur.miss;
        end else begin
            nxt.reuse = '0;
            nxt.miss  = is_miss ? CNT_W'(1) : '0;
        end
        fire = slow && !clear && (nxt.miss >= M_THR) && (nxt.reuse >= R_THR);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < DEPTH; i++)
                tbl[i] <= '0;
            mig_valid <= 1'b0;
            mig_row   <= '0;
        end else begin
            mig_valid <= 1'b0;
            if (clear) begin
                for (int i = 0; i < DEPTH; i++)
                    tbl[i] <= '0;
            end else if (slow) begin
                if (fire) begin
                    tbl[idx]  <= '0;
                    mig_valid <= 1'b1;
                    mig_row   <= row;
                end else begin
                    tbl[idx] <= nxt;
                end
            end
        end
    end

    logic any_vld;
    always_comb begin
        any_vld = 1'b0;
        for (int i = 0; i < DEPTH; i++)
            any_vld = any_vld | tbl[i].vld;
    end

    // R8: an epoch wipe leaves no live entry behind
    a_r8_wipe_empties: assert property (@(posedge clk) disable iff (rst)
        $past(clear) |-> !any_vld);

    // R6: the entry of a migrated row has been freed
    a_r6_entry_freed: assert property (@(posedge clk) disable iff (rst)
        mig_valid |-> !tbl[mig_row[IDX_W-1:0]].vld);

    // R8: the wiping access never migrates
    a_r8_no_fire_on_wipe: assert property (@(posedge clk) disable iff (rst)
        $past(clear) |-> !mig_valid);

endmodule

// File: rtl/rlf_top.sv
module rlf_top
    import rlf_pkg::*;
#(
    parameter int ROW_W     = 16,
    parameter int IDX_W     = 3,
    parameter int CNT_W     = 3,
    parameter int MISS_THR  = 3,
    parameter int REUSE_THR = 4,
    parameter int EPOCH_LEN = 64
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             acc_valid,
    input  logic [ROW_W-1:0] acc_row,
    input  logic             acc_row_hit,
    input  logic             acc_in_cache,
    output logic             mig_valid,
    output logic [ROW_W-1:0] mig_row
);
    acc_kind_e kind;
    logic      wipe;

    assign kind = classify(acc_valid, acc_in_cache, acc_row_hit);

    rlf_epoch #(.EPOCH_LEN(EPOCH_LEN)) u_epoch (
        .clk   (clk),
        .rst   (rst),
        .kind  (kind),
        .clear (wipe)
    );

    rlf_table #(
        .ROW_W     (ROW_W),
        .IDX_W     (IDX_W),
        .CNT_W     (CNT_W),
        .MISS_THR  (MISS_THR),
        .REUSE_THR (REUSE_THR)
    ) u_table (
        .clk       (clk),
        .rst       (rst),
        .kind      (kind),
        .row       (acc_row),
        .clear     (wipe),
        .mig_valid (mig_valid),
        .mig_row   (mig_row)
    );

    // R3: a cache-resident access is never followed by a migrate
    a_r3_cached_ignored: assert property (@(posedge clk) disable iff (rst)
        $past(acc_valid && acc_in_cache) |-> !mig_valid);

    // R4: a migrate always follows a slow-memory access
    a_r4_follows_access: assert property (@(posedge clk) disable iff (rst)
        mig_valid |-> $past(acc_valid && !acc_in_cache));

endmodule

// File: tb/rlf_top_tb.sv
module rlf_top_tb;
    localparam int CLK_PERIOD = 10;
    localparam int ROW_W = 12;

    logic             clk = 1'b0;
    logic             rst = 1'b1;
    logic             acc_valid = 1'b0;
    logic [ROW_W-1:0] acc_row = '0;
    logic             acc_row_hit = 1'b0;
    logic             acc_in_cache = 1'b0;
    logic             mig_valid;
    logic [ROW_W-1:0] mig_row;

    int tests = 0;
    int fails = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    rlf_top #(
        .ROW_W(ROW_W), .IDX_W(2), .CNT_W(3),
        .MISS_THR(3), .REUSE_THR(4), .EPOCH_LEN(40)
    ) u_dut (
        .clk(clk), .rst(rst),
        .acc_valid(acc_valid), .acc_row(acc_row),
        .acc_row_hit(acc_row_hit), .acc_in_cache(acc_in_cache),
        .mig_valid(mig_valid), .mig_row(mig_row)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        tests++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst = 1'b1; acc_valid = 1'b0; acc_in_cache = 1'b0; acc_row_hit = 1'b0;
        repeat (2) @(negedge clk);
        rst = 1'b0;
    endtask

    // one access; the result is registered, so it is checked just after the next edge
    task automatic access(input string req, input logic [ROW_W-1:0] row,
                          input logic hit, input logic cached, input logic exp_mig);
        @(negedge clk);
        acc_valid = 1'b1; acc_row = row; acc_row_hit = hit; acc_in_cache = cached;
        @(posedge clk);
        #1;
        check(req, {31'd0, mig_valid}, {31'd0, exp_mig});
        if (exp_mig)
            check(req, {20'd0, mig_row}, {20'd0, row});
    endtask

    task automatic idle(input string req);
        @(negedge clk);
        acc_valid = 1'b0;
        @(posedge clk);
        #1;
        check(req, {31'd0, mig_valid}, 32'd0);
    endtask

    task automatic t_reset();
        do_reset();
        #1 check("R1 reset mig_valid", {31'd0, mig_valid}, 32'd0);
        idle("R1 idle after reset");
    endtask

    // R4 then R6
    task automatic t_migrate_and_refresh();
        logic [ROW_W-1:0] a = 12'h105;
        do_reset();
        access("R4 miss 1", a, 0, 0, 0);
        access("R4 miss 2", a, 0, 0, 0);
        access("R4 miss 3", a, 0, 0, 0);
        access("R4 hit 4", a, 1, 0, 0);
        access("R4 hit 5 migrates", a, 1, 0, 1);
        idle("R4 one cycle pulse");
        access("R6 fresh 1", a, 0, 0, 0);
        access("R6 fresh 2", a, 0, 0, 0);
        access("R6 fresh 3", a, 0, 0, 0);
        access("R6 fresh 4", a, 0, 0, 0);
        access("R6 fresh 5 migrates", a, 0, 0, 1);
        idle("R6 idle");
    endtask

    // R2, R5, R9: hits add reuse only and the reuse count saturates
    task automatic t_hits_saturate();
        logic [ROW_W-1:0] b = 12'h2a2;
        do_reset();
        access("R2 first miss", b, 0, 0, 0);
        for (int i = 0; i < 14; i++)
            access("R5 hit no migrate", b, 1, 0, 0);
        access("R2 second miss", b, 0, 0, 0);
        access("R9 third miss migrates", b, 0, 0, 1);
        idle("R9 idle");
    endtask

    // R3: cache-resident accesses leave the entry untouched
    task automatic t_cached();
        logic [ROW_W-1:0] c = 12'h0f3;
        do_reset();
        access("R3 slow 1", c, 0, 0, 0);
        for (int i = 0; i < 6; i++)
            access("R3 cached ignored", c, 0, 1, 0);
        access("R3 slow 2", c, 0, 0, 0);
        access("R3 slow 3", c, 0, 0, 0);
        access("R3 slow 4", c, 0, 0, 0);
        access("R3 slow 5 migrates", c, 0, 0, 1);
        idle("R3 idle");
    endtask

    // R7: a conflicting tag replaces the entry
    task automatic t_replace();
        logic [ROW_W-1:0] d = 12'h041;
        logic [ROW_W-1:0] e = 12'h7c1;
        do_reset();
        access("R7 d 1", d, 0, 0, 0);
        access("R7 d 2", d, 0, 0, 0);
        access("R7 d 3", d, 0, 0, 0);
        access("R7 e evicts", e, 0, 0, 0);
        access("R7 d restart 1", d, 0, 0, 0);
        access("R7 d restart 2", d, 0, 0, 0);
        access("R7 d restart 3", d, 0, 0, 0);
        access("R7 d restart 4", d, 0, 0, 0);
        access("R7 d restart 5 migrates", d, 0, 0, 1);
        idle("R7 idle");
    endtask

    // R8: the 40th slow access wipes the table
    task automatic t_epoch();
        logic [ROW_W-1:0] g = 12'h200;
        do_reset();
        for (int i = 0; i < 36; i++)
            access("R8 filler", ROW_W'((i << 2) | 3), 0, 0, 0);
        access("R8 g 37", g, 0, 0, 0);
        access("R8 g 38", g, 0, 0, 0);
        access("R8 g 39", g, 0, 0, 0);
        access("R8 g 40 wipes", g, 0, 0, 0);
        access("R8 g new epoch 1", g, 0, 0, 0);
        access("R8 g 2", g, 0, 0, 0);
        access("R8 g 3", g, 0, 0, 0);
        access("R8 g 4", g, 0, 0, 0);
        access("R8 g 5 migrates", g, 0, 0, 1);
        idle("R8 idle");
    endtask

    initial begin
        t_reset();
        t_migrate_and_refresh();
        t_hits_saturate();
        t_cached();
        t_replace();
        t_epoch();
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        #(CLK_PERIOD * 100000);
        tests++;
        fails++;
        $display("FAIL watchdog actual=hung expected=done");
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

endmodule